// File: doc/BRIEF.md
# Accumulator ALU with Guarded Status Flags

This block is the 8-bit data path of a small accumulator machine, together with the status register it updates. Each cycle it receives an operation code, the accumulator value and one memory operand. It returns a combinational result and a combinational skip request. When the operation is marked valid, the arithmetic flags it produces are committed to the status register on the next rising clock edge. The carry and auxiliary-carry flags are fed back into carry-using operations.

The same status register holds two system flags, power-down and watchdog time-out. Ordinary writes to the status register cannot change them, and neither can ALU operations. Only four dedicated event inputs move them: power-up reset, halt, watchdog clear and watchdog time-out. The watchdog counter itself and the sleep logic sit outside this block and only drive those event pulses.

Top module: `acc_alu_core`

## Requirements
- R1: Opcode encoding is 0 NOP, 1 ADD, 2 ADC, 3 SUB, 4 SBC, 5 DAA, 6 AND, 7 OR, 8 XOR, 9 CPL, 10 RL, 11 RR, 12 RLC, 13 RRC, 14 INC, 15 DEC, 16 SZ, 17 SNZ, 18 SIZ, 19 SDZ. Any other code gives result 0 and changes no flag. ADD gives acc+mem and ADC gives acc+mem+C. Both set C from the carry out of bit 7, AC from the carry out of bit 3, Z when the result is zero, and OV on signed overflow.
- R2: SUB gives acc-mem and SBC gives acc-mem-(1-C). C=1 means no borrow out of bit 7 and AC=1 means no borrow out of bit 3. Z and OV (signed overflow) are also updated.
- R3: DAA adjusts the accumulator to decimal. It adds 0x06 if the low nibble is above 9 or AC=1. It then adds 0x60 if C=1, if that first step carried, or if the upper nibble is then above 9. C is set exactly when 0x60 was added, and no other flag changes.
- R4: AND, OR and XOR combine acc with mem. CPL inverts mem. These four change only Z.
- R5: RL and RR rotate mem left or right by one bit and change no flag. RLC and RRC rotate mem through C: the bit shifted out goes to C and the old C enters the vacated bit. They change only C.
- R6: INC and DEC return mem+1 and mem-1 modulo 256 and change only Z.
- R7: SZ and SNZ return mem unchanged, change no flag, and assert skip when mem is zero (SZ) or non-zero (SNZ). SIZ and SDZ behave as INC and DEC and assert skip when their result is zero. Skip is low for every other opcode and whenever op_valid is low.
- R8: result and skip are combinational. Flags change only at a rising clock edge, only when op_valid is high, and only the flags named for that opcode change.
- R9: The status layout is C bit 0, AC bit 1, Z bit 2, OV bit 3, PDF bit 4, TO bit 5, with bits 7..6 reading 0. A status write loads bits 3..0 from st_wdata and ignores bits 7..4. The write takes priority over flag updates from an operation in the same cycle.
- R10: A halt event sets PDF and clears TO.
- R11: A watchdog-clear event clears both PDF and TO and overrides halt and time-out in the same cycle.
- R12: A watchdog time-out event sets TO. It is overridden by halt or watchdog clear in the same cycle.
- R13: Reset (power-up) clears the whole status register to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| op_valid | input | 1 | Operation present; commits its flags at the edge |
| op_code | input | 5 | Operation code (encoding in R1) |
| acc_in | input | 8 | Accumulator operand |
| mem_in | input | 8 | Memory operand |
| result | output | 8 | Combinational operation result |
| skip | output | 1 | Combinational skip request |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 8 | Status write data |
| evt_halt | input | 1 | Halt event pulse |
| evt_wdt_clr | input | 1 | Watchdog clear event pulse |
| evt_wdt_timeout | input | 1 | Watchdog time-out event pulse |
| status | output | 8 | Status register contents |

## Verification
A flag register holding a wrong value shows up in one of two ways. It appears directly on status one edge after the update that produced it. It also appears on result in the very next carry-using operation (ADC, SBC, DAA, RLC, RRC), because C and AC feed back combinationally. A fault in the system-flag guard shows on status bits 5..4 one edge after the status write or event that was supposed to leave them alone or move them. The directed sequences therefore follow each flag-producing step with a carry consumer or a status read, and use status writes and events to place the register in specific states.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW    = 8;   // data width
  localparam int NF    = 4;   // arithmetic flag count
  localparam int NIB   = 4;   // nibble width for half carry and decimal adjust
  localparam int FB_C  = 0;
  localparam int FB_AC = 1;
  localparam int FB_Z  = 2;
  localparam int FB_OV = 3;
  localparam int FB_PD = 4;
  localparam int FB_TO = 5;
  localparam int OPW   = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP = 5'd0,  OP_ADD = 5'd1,  OP_ADC = 5'd2,  OP_SUB = 5'd3,
    OP_SBC = 5'd4,  OP_DAA = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR = 5'd8,  OP_CPL = 5'd9,  OP_RL  = 5'd10, OP_RR  = 5'd11,
    OP_RLC = 5'd12, OP_RRC = 5'd13, OP_INC = 5'd14, OP_DEC = 5'd15,
    OP_SZ  = 5'd16, OP_SNZ = 5'd17, OP_SIZ = 5'd18, OP_SDZ = 5'd19
  } op_e;

  typedef struct packed {
    logic [DW-1:0] sum;
    logic          c;
    logic          ac;
    logic          ov;
  } addout_t;

  // Shared adder: carries out of the low nibble and the top bit, signed overflow.
  function automatic addout_t add_core(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                       input logic cin);
    logic [NIB:0] lo;
    logic [DW:0]  full;
    addout_t      o;
    lo     = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
    full   = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    o.sum  = full[DW-1:0];
    o.c    = full[DW];
    o.ac   = lo[NIB];
    o.ov   = (a[DW-1] == b[DW-1]) && (o.sum[DW-1] != a[DW-1]);
    return o;
  endfunction

  // Decimal adjust: returns {new_carry, adjusted_value}.
  function automatic logic [DW:0] daa_core(input logic [DW-1:0] a, input logic c,
                                           input logic ac);
    logic [DW:0] t;
    logic        hi;
    t  = {1'b0, a} + (((a[NIB-1:0] > 4'd9) || ac) ? (DW+1)'(6) : (DW+1)'(0));
    hi = c || t[DW] || (t[DW-1:NIB] > 4'd9);
    t  = t + (hi ? (DW+1)'(96) : (DW+1)'(0));
    return {hi, t[DW-1:0]};
  endfunction
endpackage

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem,
  input  logic          c_in,
  input  logic          ac_in,
  output logic [DW-1:0] res,
  output logic [NF-1:0] fval,
  output logic [NF-1:0] fmask
);
  logic          is_sub;
  logic          cin;
  addout_t       ao;
  logic [DW:0]   dd;

  // One adder serves all four add/subtract forms; subtract uses the inverted operand.
  assign is_sub = (op == OP_SUB) || (op == OP_SBC);
  assign cin    = (op == OP_SUB) ? 1'b1 : (op == OP_ADD) ? 1'b0 : c_in;
  assign ao     = add_core(acc, is_sub ? ~mem : mem, cin);
  assign dd     = daa_core(acc, c_in, ac_in);

  always_comb begin
    res   = '0;
    fval  = '0;
    fmask = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        res         = ao.sum;
        fval[FB_C]  = ao.c;
        fval[FB_AC] = ao.ac;
        fval[FB_Z]  = (ao.sum == '0);
        fval[FB_OV] = ao.ov;
        fmask       = '1;
      end
      OP_DAA: begin
        res         = dd[DW-1:0];
        fval[FB_C]  = dd[DW];
        fmask[FB_C] = 1'b1;
      end
      OP_INC, OP_SIZ: begin
        res         = mem + 1'b1;
        fval[FB_Z]  = (res == '0);
        fmask[FB_Z] = 1'b1;
      end
      OP_DEC, OP_SDZ: begin
        res         = mem - 1'b1;
        fval[FB_Z]  = (res == '0);
        fmask[FB_Z] = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
(
  input  op_e           op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] mem,
  input  logic          c_in,
  output logic [DW-1:0] res,
  output logic [NF-1:0] fval,
  output logic [NF-1:0] fmask
);
  always_comb begin
    res   = '0;
    fval  = '0;
    fmask = '0;
    case (op)
      OP_AND, OP_OR, OP_XOR, OP_CPL: begin
        case (op)
          OP_AND:  res = acc & mem;
          OP_OR:   res = acc | mem;
          OP_XOR:  res = acc ^ mem;
          default: res = ~mem;
        endcase
        fval[FB_Z]  = (res == '0);
        fmask[FB_Z] = 1'b1;
      end
      OP_RL:  res = {mem[DW-2:0], mem[DW-1]};
      OP_RR:  res = {mem[0], mem[DW-1:1]};
      OP_RLC: begin
        res         = {mem[DW-2:0], c_in};
        fval[FB_C]  = mem[DW-1];
        fmask[FB_C] = 1'b1;
      end
      OP_RRC: begin
        res         = {c_in, mem[DW-1:1]};
        fval[FB_C]  = mem[0];
        fmask[FB_C] = 1'b1;
      end
      OP_SZ, OP_SNZ: res = mem;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_status_reg.sv
module alu_status_reg
  import alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [NF-1:0] upd_val,
  input  logic [NF-1:0] upd_mask,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          halt,
  input  logic          wdt_clr,
  input  logic          wdt_to,
  output logic [DW-1:0] status
);
  logic [NF-1:0] af_q;
  logic          pd_q;
  logic          to_q;
  logic          unused_wr_hi;

  // Upper write bits carry the guarded flags and spare bits; they are discarded.
  assign unused_wr_hi = ^wr_data[DW-1:NF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      af_q <= '0;
    else if (wr_en)  af_q <= wr_data[NF-1:0];
    else if (upd_en) af_q <= (af_q & ~upd_mask) | (upd_val & upd_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_q <= 1'b0;
      to_q <= 1'b0;
    end else if (wdt_clr) begin
      pd_q <= 1'b0;
      to_q <= 1'b0;
    end else if (halt) begin
      pd_q <= 1'b1;
      to_q <= 1'b0;
    end else if (wdt_to) begin
      to_q <= 1'b1;
    end
  end

  assign status = {{(DW-FB_TO-1){1'b0}}, to_q, pd_q, af_q};
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [4:0]    op_code,
  input  logic [7:0]    acc_in,
  input  logic [7:0]    mem_in,
  output logic [7:0]    result,
  output logic          skip,
  input  logic          st_wr,
  input  logic [7:0]    st_wdata,
  input  logic          evt_halt,
  input  logic          evt_wdt_clr,
  input  logic          evt_wdt_timeout,
  output logic [7:0]    status
);
  op_e           op;
  logic [DW-1:0] arith_res;
  logic [DW-1:0] logic_res;
  logic [NF-1:0] arith_fval, arith_fmask;
  logic [NF-1:0] logic_fval, logic_fmask;
  logic [NF-1:0] flag_upd_val;
  logic [NF-1:0] flag_upd_mask;
  logic          zero_test_hit;

  assign op = op_e'(op_code);

  alu_arith_unit u_arith (
    .op    (op),
    .acc   (acc_in),
    .mem   (mem_in),
    .c_in  (status[FB_C]),
    .ac_in (status[FB_AC]),
    .res   (arith_res),
    .fval  (arith_fval),
    .fmask (arith_fmask)
  );

  alu_logic_unit u_logic (
    .op    (op),
    .acc   (acc_in),
    .mem   (mem_in),
    .c_in  (status[FB_C]),
    .res   (logic_res),
    .fval  (logic_fval),
    .fmask (logic_fmask)
  );

  // Units drive zero outside their own opcodes, so merging is a plain OR.
  assign result        = arith_res | logic_res;
  assign flag_upd_val  = arith_fval | logic_fval;
  assign flag_upd_mask = arith_fmask | logic_fmask;

  always_comb begin
    case (op)
      OP_SZ:          zero_test_hit = (mem_in == '0);
      OP_SNZ:         zero_test_hit = (mem_in != '0);
      OP_SIZ, OP_SDZ: zero_test_hit = (arith_res == '0);
      default:        zero_test_hit = 1'b0;
    endcase
  end
  assign skip = op_valid && zero_test_hit;

  alu_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_en   (op_valid),
    .upd_val  (flag_upd_val),
    .upd_mask (flag_upd_mask),
    .wr_en    (st_wr),
    .wr_data  (st_wdata),
    .halt     (evt_halt),
    .wdt_clr  (evt_wdt_clr),
    .wdt_to   (evt_wdt_timeout),
    .status   (status)
  );
endmodule

// File: rtl/acc_alu_core_chk.sv
module acc_alu_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] op_code,
  input logic       skip,
  input logic       st_wr,
  input logic [7:0] st_wdata,
  input logic       evt_halt,
  input logic       evt_wdt_clr,
  input logic       evt_wdt_timeout,
  input logic [7:0] status,
  input logic [3:0] flag_upd_mask
);
  assert_spare_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);

  assert_wr_loads_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> status[3:0] == $past(st_wdata[3:0]));

  assert_wr_spares_sys_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !evt_halt && !evt_wdt_clr && !evt_wdt_timeout) |=> $stable(status[5:4]));

  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_halt && !evt_wdt_clr) |=> status[5:4] == 2'b01);

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wdt_clr |=> status[5:4] == 2'b00);

  assert_timeout_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_wdt_timeout && !evt_halt && !evt_wdt_clr) |=> status[5]);

  assert_unmasked_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !st_wr) |=> ((status[3:0] & ~$past(flag_upd_mask)) ==
                              ($past(status[3:0]) & ~$past(flag_upd_mask))));

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !st_wr) |=> $stable(status[3:0]));

  assert_skip_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (op_valid && op_code >= 5'd16 && op_code <= 5'd19));
endmodule

bind acc_alu_core acc_alu_core_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .op_valid        (op_valid),
  .op_code         (op_code),
  .skip            (skip),
  .st_wr           (st_wr),
  .st_wdata        (st_wdata),
  .evt_halt        (evt_halt),
  .evt_wdt_clr     (evt_wdt_clr),
  .evt_wdt_timeout (evt_wdt_timeout),
  .status          (status),
  .flag_upd_mask   (flag_upd_mask)
);

// File: tb/acc_alu_core_tb.sv
module acc_alu_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = 5'd0;
  logic [7:0] acc_in = 8'h00;
  logic [7:0] mem_in = 8'h00;
  logic [7:0] result;
  logic       skip;
  logic       st_wr = 1'b0;
  logic [7:0] st_wdata = 8'h00;
  logic       evt_halt = 1'b0;
  logic       evt_wdt_clr = 1'b0;
  logic       evt_wdt_timeout = 1'b0;
  logic [7:0] status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [4:0] ADD = 5'd1, ADC = 5'd2, SUB = 5'd3, SBC = 5'd4, DAA = 5'd5,
                         AND_ = 5'd6, OR_ = 5'd7, XOR_ = 5'd8, CPL = 5'd9, RL = 5'd10,
                         RR = 5'd11, RLC = 5'd12, RRC = 5'd13, INC = 5'd14, DEC = 5'd15,
                         SZ = 5'd16, SNZ = 5'd17, SIZ = 5'd18, SDZ = 5'd19;

  always #10 clk = ~clk;

  acc_alu_core u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .mem_in(mem_in), .result(result), .skip(skip),
    .st_wr(st_wr), .st_wdata(st_wdata), .evt_halt(evt_halt),
    .evt_wdt_clr(evt_wdt_clr), .evt_wdt_timeout(evt_wdt_timeout), .status(status)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // One operation: check result/skip mid-cycle, status after the edge.
  task automatic run_op(input string tag, input logic [4:0] op, input logic [7:0] a,
                        input logic [7:0] m, input logic [7:0] exp_res,
                        input logic exp_skip, input logic [7:0] exp_st);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; acc_in = a; mem_in = m;
    #2;
    chk({tag, " result"}, result, exp_res);
    chk({tag, " skip"}, {7'd0, skip}, {7'd0, exp_skip});
    @(negedge clk);
    op_valid = 1'b0;
    chk({tag, " status"}, status, exp_st);
  endtask

  task automatic wr_st(input string tag, input logic [7:0] d, input logic [7:0] exp_st);
    @(negedge clk);
    st_wr = 1'b1; st_wdata = d;
    @(negedge clk);
    st_wr = 1'b0;
    chk(tag, status, exp_st);
  endtask

  task automatic sys_evt(input string tag, input logic h, input logic c, input logic t,
                         input logic [7:0] exp_st);
    @(negedge clk);
    evt_halt = h; evt_wdt_clr = c; evt_wdt_timeout = t;
    @(negedge clk);
    evt_halt = 1'b0; evt_wdt_clr = 1'b0; evt_wdt_timeout = 1'b0;
    chk(tag, status, exp_st);
  endtask

  task automatic t_reset;
    #2;
    chk("R13 status during reset", status, 8'h00);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 status after reset", status, 8'h00);
  endtask

  task automatic t_add;
    run_op("R1 ADD half carry", ADD, 8'h0F, 8'h01, 8'h10, 1'b0, 8'h02);
    run_op("R1 ADD carry zero ovf", ADD, 8'h80, 8'h80, 8'h00, 1'b0, 8'h0D);
    run_op("R1 ADC with carry", ADC, 8'h7F, 8'h00, 8'h80, 1'b0, 8'h0A);
  endtask

  task automatic t_sub;
    run_op("R2 SUB no borrow", SUB, 8'h05, 8'h03, 8'h02, 1'b0, 8'h03);
    run_op("R2 SUB borrow", SUB, 8'h03, 8'h05, 8'hFE, 1'b0, 8'h00);
    run_op("R2 SBC borrow in", SBC, 8'h05, 8'h05, 8'hFF, 1'b0, 8'h00);
    run_op("R2 SBC nibble borrow", SBC, 8'h10, 8'h01, 8'h0E, 1'b0, 8'h01);
  endtask

  task automatic t_daa;
    run_op("R3 DAA carry in", DAA, 8'h12, 8'h00, 8'h72, 1'b0, 8'h01);
    wr_st("R3 preset clear", 8'h00, 8'h00);
    run_op("R3 DAA both nibbles", DAA, 8'h9A, 8'h00, 8'h00, 1'b0, 8'h01);
    wr_st("R3 preset AC", 8'h02, 8'h02);
    run_op("R3 DAA from AC", DAA, 8'h21, 8'h00, 8'h27, 1'b0, 8'h02);
  endtask

  task automatic t_logic;
    wr_st("R4 preset", 8'h0F, 8'h0F);
    run_op("R4 AND zero", AND_, 8'hF0, 8'h0F, 8'h00, 1'b0, 8'h0F);
    run_op("R4 XOR", XOR_, 8'hFF, 8'h0F, 8'hF0, 1'b0, 8'h0B);
    run_op("R4 OR zero", OR_, 8'h00, 8'h00, 8'h00, 1'b0, 8'h0F);
    run_op("R4 CPL to zero", CPL, 8'h33, 8'hFF, 8'h00, 1'b0, 8'h0F);
    run_op("R4 CPL", CPL, 8'h33, 8'h5A, 8'hA5, 1'b0, 8'h0B);
  endtask

  task automatic t_rot;
    run_op("R5 RL", RL, 8'h00, 8'h81, 8'h03, 1'b0, 8'h0B);
    run_op("R5 RR", RR, 8'h00, 8'h81, 8'hC0, 1'b0, 8'h0B);
    run_op("R5 RLC", RLC, 8'h00, 8'h40, 8'h81, 1'b0, 8'h0A);
    run_op("R5 RRC", RRC, 8'h00, 8'h01, 8'h00, 1'b0, 8'h0B);
  endtask

  task automatic t_incdec;
    run_op("R6 INC wrap", INC, 8'h00, 8'hFF, 8'h00, 1'b0, 8'h0F);
    run_op("R6 DEC", DEC, 8'h00, 8'h05, 8'h04, 1'b0, 8'h0B);
    run_op("R6 INC sign", INC, 8'h00, 8'h7F, 8'h80, 1'b0, 8'h0B);
  endtask

  task automatic t_skip;
    run_op("R7 SZ hit", SZ, 8'h00, 8'h00, 8'h00, 1'b1, 8'h0B);
    run_op("R7 SNZ miss", SNZ, 8'h00, 8'h00, 8'h00, 1'b0, 8'h0B);
    run_op("R7 SNZ hit", SNZ, 8'h00, 8'h10, 8'h10, 1'b1, 8'h0B);
    run_op("R7 SZ miss", SZ, 8'h00, 8'h03, 8'h03, 1'b0, 8'h0B);
    run_op("R7 SIZ hit", SIZ, 8'h00, 8'hFF, 8'h00, 1'b1, 8'h0F);
    run_op("R7 SDZ miss", SDZ, 8'h00, 8'h05, 8'h04, 1'b0, 8'h0B);
    run_op("R7 SDZ hit", SDZ, 8'h00, 8'h01, 8'h00, 1'b1, 8'h0F);
    run_op("R7 ADD no skip", ADD, 8'h00, 8'h00, 8'h00, 1'b0, 8'h04);
  endtask

  task automatic t_gating;
    @(negedge clk);
    op_valid = 1'b0; op_code = SZ; mem_in = 8'h00;
    #2;
    chk("R7 skip gated by op_valid", {7'd0, skip}, 8'h00);
    @(negedge clk);
    op_code = ADD; acc_in = 8'h80; mem_in = 8'h80;
    @(negedge clk);
    chk("R8 no update without op_valid", status, 8'h04);
  endtask

  task automatic t_statwr;
    wr_st("R9 write masks upper bits", 8'hFF, 8'h0F);
    @(negedge clk);
    st_wr = 1'b1; st_wdata = 8'h00;
    op_valid = 1'b1; op_code = ADD; acc_in = 8'h80; mem_in = 8'h80;
    @(negedge clk);
    st_wr = 1'b0; op_valid = 1'b0;
    chk("R9 write beats op flags", status, 8'h00);
  endtask

  task automatic t_sysflags;
    sys_evt("R10 halt", 1'b1, 1'b0, 1'b0, 8'h10);
    sys_evt("R12 timeout", 1'b0, 1'b0, 1'b1, 8'h30);
    wr_st("R9 write cannot clear PDF TO", 8'h00, 8'h30);
    wr_st("R9 write low keeps PDF TO", 8'h05, 8'h35);
    run_op("R9 op keeps PDF TO", ADD, 8'h80, 8'h80, 8'h00, 1'b0, 8'h3D);
    sys_evt("R11 clear", 1'b0, 1'b1, 1'b0, 8'h0D);
    sys_evt("R12 halt beats timeout", 1'b1, 1'b0, 1'b1, 8'h1D);
    sys_evt("R11 clear beats halt", 1'b1, 1'b1, 1'b0, 8'h0D);
    sys_evt("R12 timeout alone", 1'b0, 1'b0, 1'b1, 8'h2D);
  endtask

  task automatic t_powerup;
    @(negedge clk);
    rst_n = 1'b0;
    #2;
    chk("R13 power-up clears all", status, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 stays clear", status, 8'h00);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_daa();
    t_logic();
    t_rot();
    t_incdec();
    t_skip();
    t_gating();
    t_statwr();
    t_sysflags();
    t_powerup();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule